// File: doc/BRIEF.md
# UART Modem Control and Status Unit

This block holds the two modem-handshake registers of a UART: a control register that drives the outbound handshake lines and a few mode bits, and a status register that reports the inbound handshake lines and records their changes. The inbound lines are active-low pins. Each passes through a two-flop synchronizer and is reported as an active-high level. A change on a line latches a sticky change flag. All change flags clear when software reads the status register.

A local loopback mode is used for self-test. In this mode the low control bits stand in for the inbound pins, in a crossed order. The serial transmit stream is routed back to the receive path, and the transmit pin is held idle. The upper three control bits are protected. They take writes only while an external feature-unlock input is high. An auto-RTS input gives the RTS pin to an external flow-control engine. Access uses a simple bus: a one-bit register select, write and read strobes, and a combinational read-data port.

Top module: `uart_mdm_unit`

## Requirements
- R1: `dtr_no` is the inverse of control bit 0: writing 1 drives it low (active) and writing 0 drives it high, from the cycle after the write.
- R2: `rts_no` is the inverse of control bit 1 while `auto_rts_i` is 0. While `auto_rts_i` is 1 it is the inverse of `flow_rts_i`.
- R3: `irq_oe_o` equals control bit 3 and `prescale_div4_o` equals control bit 7 (1 = divide input clock by four).
- R4: Outside loopback (control bit 4 = 0), status bits 7..4 read the inverted CD, RI, DSR and CTS pins. A pin change shows there after two rising clock edges.
- R5: With control bit 4 set, status bit 4 shows control bit 1, bit 5 shows control bit 0, bit 6 shows control bit 2 and bit 7 shows control bit 3. `ser_rx_o` follows `ser_tx_i` and `ser_tx_o` is held 1. Outside loopback, `ser_tx_o` follows `ser_tx_i` and `ser_rx_o` follows `ser_rx_i`.
- R6: Status bits 0, 1 and 3 set one edge after the reported CTS, DSR or CD level changes, in either direction.
- R7: Status bit 2 sets only when the reported RI level goes from 1 to 0, which is the pin going low to high. A 0-to-1 RI change sets nothing.
- R8: Change flags stay set until a status read (`reg_sel_i`=1, `rd_en_i`=1). The read returns them and clears them at the end of that cycle.
- R9: A change detected in the same cycle as a status read leaves its flag set after the read.
- R10: Control bits 4..0 take every control write (`reg_sel_i`=0, `wr_en_i`=1). Bits 7..5 take it only while `feat_unlock_i` is 1. The control register reads back with `reg_sel_i`=0.
- R11: A write with `reg_sel_i`=1 changes neither the control register nor the status flags.
- R12: Reset clears the control register and all flags, so `dtr_no` and `rts_no` are high and `irq_oe_o` is low. No flag is raised by reset, even when a pin is held active through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register select: 0 control, 1 status |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; on status clears the change flags |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| feat_unlock_i | input | 1 | Write enable for control bits 7..5 |
| auto_rts_i | input | 1 | Hand the RTS pin to flow control |
| flow_rts_i | input | 1 | Flow-control RTS request, active high |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low |
| ri_ni | input | 1 | Ring-indicator pin, active low |
| cd_ni | input | 1 | Carrier-detect pin, active low |
| dtr_no | output | 1 | Data-terminal-ready pin, active low |
| rts_no | output | 1 | Request-to-send pin, active low |
| irq_oe_o | output | 1 | Interrupt pin output enable |
| prescale_div4_o | output | 1 | Clock prescaler select |
| ser_tx_i | input | 1 | Serial stream from the transmitter |
| ser_tx_o | output | 1 | Serial transmit pin |
| ser_rx_i | input | 1 | Serial receive pin |
| ser_rx_o | output | 1 | Serial stream to the receiver |

## Verification
The properties assume that the handshake pins are the only inputs that are asynchronous. They also assume that the bus strobes and `feat_unlock_i`, `auto_rts_i` and `flow_rts_i` are steady around the rising edge. The bench changes every input on the falling clock edge, including the pins, so each pin change lands at a known point in the synchronizer. Reads and writes last exactly one cycle. The coincident-read case is set up by raising the read strobe in the cycle in which the synchronized level first differs from the stored previous level.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned LINE_N = 4;

  // inbound line order; also the delta bit order of the status register
  localparam int unsigned L_CTS = 0;
  localparam int unsigned L_DSR = 1;
  localparam int unsigned L_RI  = 2;
  localparam int unsigned L_CD  = 3;

  // control register fields
  localparam int unsigned C_DTR   = 0;
  localparam int unsigned C_RTS   = 1;
  localparam int unsigned C_AUX   = 2;
  localparam int unsigned C_IRQ   = 3;
  localparam int unsigned C_LOOP  = 4;
  localparam int unsigned C_LOCK  = 5;  // first write-protected bit
  localparam int unsigned C_PRESC = 7;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/uart_mdm_sync.sv
module uart_mdm_sync #(
  parameter int unsigned       WIDTH   = 4,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/uart_mdm_ctrl_reg.sv
module uart_mdm_ctrl_reg #(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned LOCK_LSB = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             unlock_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o
);
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q[LOCK_LSB-1:0] <= wdata_i[LOCK_LSB-1:0];
      if (unlock_i) ctrl_q[REG_W-1:LOCK_LSB] <= wdata_i[REG_W-1:LOCK_LSB];
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/uart_mdm_status.sv
module uart_mdm_status #(
  parameter int unsigned       LINES      = 4,
  parameter int unsigned       ARM_CYC    = 3,
  parameter logic [LINES-1:0]  TRAIL_ONLY = 4'b0100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lvl_i,
  input  logic             rd_clr_i,
  output logic [LINES-1:0] evt_o,
  output logic [LINES-1:0] prev_o,
  output logic [LINES-1:0] delta_o
);
  localparam int unsigned ARM_W = $clog2(ARM_CYC + 1);

  logic [ARM_W-1:0] arm_cnt;
  logic             armed;
  logic [LINES-1:0] prev_q, raw, delta_q;

  assign armed = (arm_cnt == ARM_W'(ARM_CYC));

  // mask edges until the synchronizer and prev_q hold real pin levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     arm_cnt <= '0;
    else if (!armed) arm_cnt <= arm_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_edge
    if (TRAIL_ONLY[i]) begin : g_trail
      assign raw[i] = prev_q[i] & ~lvl_i[i];
    end else begin : g_any
      assign raw[i] = prev_q[i] ^ lvl_i[i];
    end
  end

  assign evt_o = armed ? raw : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       delta_q <= '0;
    else if (rd_clr_i) delta_q <= evt_o;
    else               delta_q <= delta_q | evt_o;
  end

  assign prev_o  = prev_q;
  assign delta_o = delta_q;
endmodule

// File: rtl/uart_mdm_unit.sv
module uart_mdm_unit
  import uart_mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_sel_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       feat_unlock_i,
  input  logic       auto_rts_i,
  input  logic       flow_rts_i,
  input  logic       cts_ni,
  input  logic       dsr_ni,
  input  logic       ri_ni,
  input  logic       cd_ni,
  output logic       dtr_no,
  output logic       rts_no,
  output logic       irq_oe_o,
  output logic       prescale_div4_o,
  input  logic       ser_tx_i,
  output logic       ser_tx_o,
  input  logic       ser_rx_i,
  output logic       ser_rx_o
);
  localparam logic [LINE_N-1:0] RI_MASK = LINE_N'(1) << L_RI;

  logic [REG_W-1:0]  ctrl_q;
  logic [LINE_N-1:0] pin_n, pin_s, lvl, evt, prev_q, delta_q;
  logic              loop_en, ctrl_we, stat_rd;

  assign ctrl_we = wr_en_i && (reg_sel_e'(reg_sel_i) == SEL_CTRL);
  assign stat_rd = rd_en_i && (reg_sel_e'(reg_sel_i) == SEL_STAT);

  uart_mdm_ctrl_reg #(
    .REG_W   (REG_W),
    .LOCK_LSB(C_LOCK)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .unlock_i(feat_unlock_i),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl_q)
  );

  always_comb begin
    pin_n        = '0;
    pin_n[L_CTS] = cts_ni;
    pin_n[L_DSR] = dsr_ni;
    pin_n[L_RI]  = ri_ni;
    pin_n[L_CD]  = cd_ni;
  end

  uart_mdm_sync #(
    .WIDTH  (LINE_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL({LINE_N{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_n),
    .q_o   (pin_s)
  );

  assign loop_en = ctrl_q[C_LOOP];

  // loopback crosses DTR onto DSR and RTS onto CTS
  always_comb begin
    if (loop_en) begin
      lvl        = '0;
      lvl[L_CTS] = ctrl_q[C_RTS];
      lvl[L_DSR] = ctrl_q[C_DTR];
      lvl[L_RI]  = ctrl_q[C_AUX];
      lvl[L_CD]  = ctrl_q[C_IRQ];
    end else begin
      lvl = ~pin_s;
    end
  end

  uart_mdm_status #(
    .LINES     (LINE_N),
    .ARM_CYC   (SYNC_STAGES + 1),
    .TRAIL_ONLY(RI_MASK)
  ) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (lvl),
    .rd_clr_i(stat_rd),
    .evt_o   (evt),
    .prev_o  (prev_q),
    .delta_o (delta_q)
  );

  assign rdata_o = (reg_sel_e'(reg_sel_i) == SEL_STAT) ? {lvl, delta_q} : ctrl_q;

  assign dtr_no          = ~ctrl_q[C_DTR];
  assign rts_no          = auto_rts_i ? ~flow_rts_i : ~ctrl_q[C_RTS];
  assign irq_oe_o        = ctrl_q[C_IRQ];
  assign prescale_div4_o = ctrl_q[C_PRESC];

  assign ser_tx_o = loop_en ? 1'b1 : ser_tx_i;
  assign ser_rx_o = loop_en ? ser_tx_i : ser_rx_i;
endmodule

// File: rtl/uart_mdm_unit_chk.sv
module uart_mdm_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_sel_i,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [1:0] wd_lo_i,
  input logic       feat_unlock_i,
  input logic       auto_rts_i,
  input logic       dtr_no,
  input logic       rts_no,
  input logic       ser_tx_i,
  input logic       ser_tx_o,
  input logic       ser_rx_o,
  input logic [7:0] ctrl_q,
  input logic [3:0] delta_q,
  input logic [3:0] evt,
  input logic       prev_ri,
  input logic       lvl_ri
);
  p_dtr_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !reg_sel_i) |=> (dtr_no == !$past(wd_lo_i[0])));

  p_rts_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !reg_sel_i) |=> (auto_rts_i || (rts_no == !$past(wd_lo_i[1]))));

  p_loop_serial_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[4] |-> (ser_tx_o && (ser_rx_o == ser_tx_i)));

  p_ri_trailing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(delta_q[2]) |-> ($past(prev_ri) && !$past(lvl_ri)));

  p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && reg_sel_i) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  p_read_keeps_new_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && reg_sel_i) |=> ((delta_q & ~$past(evt)) == 4'b0 && (delta_q & $past(evt)) == $past(evt)));

  p_lock_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !reg_sel_i && !feat_unlock_i) |=> $stable(ctrl_q[7:5]));

  p_stat_write_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_sel_i) |=> $stable(ctrl_q));
endmodule

bind uart_mdm_unit uart_mdm_unit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_sel_i    (reg_sel_i),
  .wr_en_i      (wr_en_i),
  .rd_en_i      (rd_en_i),
  .wd_lo_i      (wdata_i[1:0]),
  .feat_unlock_i(feat_unlock_i),
  .auto_rts_i   (auto_rts_i),
  .dtr_no       (dtr_no),
  .rts_no       (rts_no),
  .ser_tx_i     (ser_tx_i),
  .ser_tx_o     (ser_tx_o),
  .ser_rx_o     (ser_rx_o),
  .ctrl_q       (ctrl_q),
  .delta_q      (delta_q),
  .evt          (evt),
  .prev_ri      (prev_q[2]),
  .lvl_ri       (lvl[2])
);

// File: tb/uart_mdm_unit_test.sv
module uart_mdm_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic unlock = 1'b0, auto_rts = 1'b0, flow_rts = 1'b0;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic tx_in = 1'b1, rx_pin = 1'b1;
  logic [7:0] rdata;
  logic dtr_n, rts_n, irq_oe, presc, tx_pin, rx_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_mdm_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .feat_unlock_i(unlock),
    .auto_rts_i(auto_rts), .flow_rts_i(flow_rts),
    .cts_ni(cts_n), .dsr_ni(dsr_n), .ri_ni(ri_n), .cd_ni(cd_n),
    .dtr_no(dtr_n), .rts_no(rts_n), .irq_oe_o(irq_oe), .prescale_div4_o(presc),
    .ser_tx_i(tx_in), .ser_tx_o(tx_pin), .ser_rx_i(rx_pin), .ser_rx_o(rx_out)
  );

  // {wdata[22:15], unlock, auto, flow, ctrl readback[11:4], {dtr_n,rts_n,irq_oe,presc}}
  localparam logic [22:0] VEC [8] = '{
    {8'h03, 3'b000, 8'h03, 4'b0000},
    {8'hE8, 3'b000, 8'h08, 4'b1110},
    {8'hE8, 3'b100, 8'hE8, 4'b1111},
    {8'h02, 3'b000, 8'hE2, 4'b1001},
    {8'h02, 3'b011, 8'hE2, 4'b1001},
    {8'h00, 3'b011, 8'hE0, 4'b1001},
    {8'h00, 3'b110, 8'h00, 4'b1100},
    {8'h0B, 3'b100, 8'h0B, 4'b0010}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic s, input logic [7:0] d);
    sel = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; sel = 1'b0;
  endtask

  task automatic peek_stat(input string req, input logic [7:0] exp);
    sel = 1'b1; #1;
    chk(req, rdata, exp);
    sel = 1'b0;
  endtask

  task automatic read_stat(input string req, input logic [7:0] exp);
    sel = 1'b1; rd = 1'b1; #1;
    chk(req, rdata, exp);
    @(negedge clk);
    rd = 1'b0; sel = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 pins", {4'h0, dtr_n, rts_n, irq_oe, presc}, 8'h0C);
    chk("R12 ctrl", rdata, 8'h00);
    wait_n(5);
    peek_stat("R12 no flag", 8'h00);

    // control register vectors: R1 R2 R3 R10
    for (int i = 0; i < 8; i++) begin
      unlock = VEC[i][14]; auto_rts = VEC[i][13]; flow_rts = VEC[i][12];
      wr_reg(1'b0, VEC[i][22:15]);
      #1;
      chk("R1/R2/R3 outs", {4'h0, dtr_n, rts_n, irq_oe, presc}, {4'h0, VEC[i][3:0]});
      chk("R10 readback", rdata, VEC[i][11:4]);
    end
    unlock = 1'b0; auto_rts = 1'b0; flow_rts = 1'b0;

    // R4 sync latency, R6 both edges, R8 read clear
    dsr_n = 1'b0;
    @(negedge clk); peek_stat("R4 edge1", 8'h00);
    @(negedge clk); peek_stat("R4 edge2", 8'h20);
    @(negedge clk); peek_stat("R6 dsr rise", 8'h22);
    read_stat("R8 read", 8'h22);
    peek_stat("R8 cleared", 8'h20);
    dsr_n = 1'b1; wait_n(3);
    peek_stat("R6 dsr fall", 8'h02);
    read_stat("R8 read2", 8'h02);

    // R8 flag held without read
    cd_n = 1'b0; wait_n(8);
    peek_stat("R8 hold", 8'h88);
    read_stat("R8 read3", 8'h88);
    cd_n = 1'b1; wait_n(3);
    read_stat("R6 cd fall", 8'h08);
    peek_stat("R8 clear3", 8'h00);

    // R7 ring trailing edge only
    ri_n = 1'b0; wait_n(3);
    peek_stat("R7 ring start no flag", 8'h40);
    ri_n = 1'b1; wait_n(3);
    peek_stat("R7 ring end flag", 8'h04);
    read_stat("R7 read", 8'h04);

    // R9 read in the cycle the change is detected
    cts_n = 1'b0; wait_n(2);
    read_stat("R9 before", 8'h10);
    peek_stat("R9 kept", 8'h11);
    read_stat("R9 read", 8'h11);
    cts_n = 1'b1; wait_n(3);
    read_stat("R6 cts fall", 8'h01);

    // R11 write to status address ignored
    wr_reg(1'b1, 8'hFF);
    peek_stat("R11 flags", 8'h00);
    #1; chk("R11 ctrl", rdata, 8'h0B);

    // R5 loopback crossing
    wr_reg(1'b0, 8'h15);
    peek_stat("R5 levels a", 8'h60);
    @(negedge clk); peek_stat("R5 flags a", 8'h62);
    tx_in = 1'b0; rx_pin = 1'b1; #1;
    chk("R5 loop serial0", {6'h0, tx_pin, rx_out}, 8'h02);
    tx_in = 1'b1; rx_pin = 1'b0; #1;
    chk("R5 loop serial1", {6'h0, tx_pin, rx_out}, 8'h03);
    read_stat("R5 read a", 8'h62);
    wr_reg(1'b0, 8'h1A);
    peek_stat("R5 levels b", 8'h90);
    @(negedge clk); peek_stat("R5 R7 flags b", 8'h9F);
    read_stat("R5 read b", 8'h9F);
    wr_reg(1'b0, 8'h00);
    peek_stat("R5 exit levels", 8'h00);
    tx_in = 1'b0; rx_pin = 1'b1; #1;
    chk("R5 normal serial", {6'h0, tx_pin, rx_out}, 8'h01);
    @(negedge clk); read_stat("R5 exit flags", 8'h09);

    // R12 reset with a pin held active
    cts_n = 1'b0; rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(6);
    peek_stat("R12 active pin no flag", 8'h10);
    #1; chk("R12 ctrl after reset", {rdata[3:0], dtr_n, rts_n, irq_oe, presc}, 8'h0C);
    cts_n = 1'b1; wait_n(3);
    peek_stat("R6 after reset", 8'h01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule